// File: doc/BRIEF.md
# Gated Period-Match Timer

An up-counting timer with a configurable width (16 bits by default) that runs off a single system clock. Its count pulses come from one of four sources. The first is every system clock. The second is system clocks qualified by a level on an external pin, called gating. The third is rising edges of that pin after a two-stage synchroniser. The fourth is rising edges of the pin taken from a single capture stage, the short-latency asynchronous option. The pulses pass through a prescaler before they reach the counter. Each prescaled tick compares the counter with a period register. On equality the counter returns to zero and a sticky event flag is raised.

Software configures the timer through a 16-bit control word and writes the period and the counter directly. It clears the flag with a one-cycle strobe. All interfaces are plain control strobes and levels. No data stream passes through the block, so there is no valid/ready handshake and no back-pressure. Every write takes effect on the clock edge where its strobe is high.

Top module: `period_timer`

## Requirements
- R1: After reset the counter reads 0, the period reads all ones, the control word reads 0 and the event flag is clear.
- R2: While control bit 15 (run) is 0, the counter holds its value unless software writes it.
- R3: With run set and bit 1 = 0, bit 7 = 0 and prescale 1, the counter rises by one per clock, starting on the second edge after the control write. The control readback keeps only bits 15, 7, 5, 4, 2 and 1; all other bits read 0.
- R4: Control bits 5:4 set the prescale: 00 gives 1, 01 gives 8, 10 gives 64 and 11 gives 256. The counter advances once per that many source pulses.
- R5: On a tick where the counter equals the period, the counter becomes 0 and the event flag is set. A period of 0 therefore holds the counter at 0 and flags on every tick.
- R6: The event flag stays set until flag_clr is pulsed. A new event in the same cycle as the clear leaves the flag set.
- R7: With bit 1 = 0 and bit 7 = 1, a source pulse occurs only on clocks where the synchronised pin level is high, two edges after the pin. A falling edge of the synchronised gate sets the event flag.
- R8: With bit 1 = 1, bit 7 has no effect. A pin held high yields one count, not one count per clock.
- R9: With bit 1 = 1 and bit 2 = 1, each pin rising edge gives one source pulse. The counter changes on the third clock edge after the pin rises.
- R10: With bit 1 = 1 and bit 2 = 0, each pin rising edge gives one source pulse. The counter changes on the second clock edge after the pin rises.
- R11: A counter write loads the value and restarts the prescale count; the write wins over a tick in the same cycle. A control write also restarts the prescale count and suppresses that cycle's tick.
- R12: A period write is visible on period_q one edge later and is used for the next comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every register is on it |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 16 | Control word: 15 run, 7 gate, 5:4 prescale, 2 sync, 1 external source |
| per_we | input | 1 | Period write strobe |
| per_wdata | input | W | Period value |
| cnt_we | input | 1 | Counter write strobe |
| cnt_wdata | input | W | Counter load value |
| flag_clr | input | 1 | Clears the event flag |
| ext_pin | input | 1 | External clock or gate pin |
| cfg_q | output | 16 | Control word readback |
| period_q | output | W | Period register |
| count_q | output | W | Counter value |
| event_flag | output | 1 | Sticky event flag |

## Verification
The latency of each result depends on where it starts. A register write shows at its readback one edge after the strobe. An internal count shows one edge after the cycle in which its source pulse is formed. A pin edge reaches the counter two edges later on the single-stage path and three edges later on the synchronised path. A gate level needs three edges to take effect. The bench drives inputs on falling edges and compares after every rising edge against a cycle model stepped on that same edge, so each result is checked exactly where it is due. Directed sequences also pin the edge counts for the pin paths, the prescale boundary and the wrap.

// File: rtl/timer_pkg.sv
package timer_pkg;

  localparam int CTRL_W   = 16;
  localparam int B_RUN    = 15;
  localparam int B_GATE   = 7;
  localparam int B_PS_HI  = 5;
  localparam int B_PS_LO  = 4;
  localparam int B_SYNC   = 2;
  localparam int B_SRC    = 1;
  localparam logic [CTRL_W-1:0] CTRL_MASK = 16'h80B6;

  typedef enum logic [1:0] {PS_1 = 2'd0, PS_8 = 2'd1, PS_64 = 2'd2, PS_256 = 2'd3} ps_sel_e;

  typedef enum logic [1:0] {
    MODE_INT       = 2'd0,
    MODE_INT_GATED = 2'd1,
    MODE_EXT_SYNC  = 2'd2,
    MODE_EXT_ASYNC = 2'd3
  } tmr_mode_e;

  function automatic int unsigned ps_ratio(ps_sel_e s);
    case (s)
      PS_1:    return 1;
      PS_8:    return 8;
      PS_64:   return 64;
      default: return 256;
    endcase
  endfunction

  function automatic tmr_mode_e mode_of(logic [CTRL_W-1:0] w);
    if (w[B_SRC])       return w[B_SYNC] ? MODE_EXT_SYNC : MODE_EXT_ASYNC;
    else if (w[B_GATE]) return MODE_INT_GATED;
    else                return MODE_INT;
  endfunction

endpackage

// File: rtl/tmr_edge_sync.sv
module tmr_edge_sync #(
  parameter int SYNC_DEPTH = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pin,
  output logic rise_fast,
  output logic rise_safe,
  output logic level_safe,
  output logic fall_safe
);
  localparam int CHAIN = SYNC_DEPTH + 1;

  logic [CHAIN-1:0] sh;

  always_ff @(posedge clk) begin
    if (!rst_n) sh <= '0;
    else        sh <= {sh[CHAIN-2:0], pin};
  end

  assign rise_fast  = sh[0] & ~sh[1];
  assign level_safe = sh[SYNC_DEPTH-1];
  assign rise_safe  = sh[SYNC_DEPTH-1] & ~sh[SYNC_DEPTH];
  assign fall_safe  = sh[SYNC_DEPTH] & ~sh[SYNC_DEPTH-1];
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler
  import timer_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  logic    restart,
  input  logic    pulse,
  input  ps_sel_e sel,
  output logic    tick
);
  localparam int PS_W = $clog2(256);

  logic [PS_W-1:0] acc;
  logic [PS_W-1:0] limit;
  logic            at_limit;

  assign limit    = PS_W'(ps_ratio(sel) - 1);
  assign at_limit = (acc == limit);
  assign tick     = pulse & ~restart & at_limit;

  always_ff @(posedge clk) begin
    if (!rst_n || restart) acc <= '0;
    else if (pulse)        acc <= at_limit ? '0 : acc + 1'b1;
  end
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         tick,
  input  logic [W-1:0] period,
  input  logic         gate_fall,
  input  logic         flag_clr,
  output logic [W-1:0] count,
  output logic         flag
);
  logic hit;
  logic set_flag;

  assign hit      = tick & ~load & (count == period);
  assign set_flag = hit | gate_fall;

  always_ff @(posedge clk) begin
    if (!rst_n)    count <= '0;
    else if (load) count <= load_val;
    else if (tick) count <= (count == period) ? '0 : count + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)        flag <= 1'b0;
    else if (set_flag) flag <= 1'b1;
    else if (flag_clr) flag <= 1'b0;
  end
endmodule

// File: rtl/period_timer.sv
module period_timer
  import timer_pkg::*;
#(
  parameter int W = 16,
  parameter int SYNC_DEPTH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_we,
  input  logic [CTRL_W-1:0] cfg_wdata,
  input  logic              per_we,
  input  logic [W-1:0]      per_wdata,
  input  logic              cnt_we,
  input  logic [W-1:0]      cnt_wdata,
  input  logic              flag_clr,
  input  logic              ext_pin,
  output logic [CTRL_W-1:0] cfg_q,
  output logic [W-1:0]      period_q,
  output logic [W-1:0]      count_q,
  output logic              event_flag
);
  logic [CTRL_W-1:0] ctrl;
  logic [W-1:0]      per_r;
  tmr_mode_e         mode;
  logic              run;
  logic              rise_fast, rise_safe, level_safe, fall_safe;
  logic              src_pulse, tick_w, gate_fall_evt;

  always_ff @(posedge clk) begin
    if (!rst_n)      ctrl <= '0;
    else if (cfg_we) ctrl <= cfg_wdata & CTRL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rst_n)      per_r <= '1;
    else if (per_we) per_r <= per_wdata;
  end

  assign mode = mode_of(ctrl);
  assign run  = ctrl[B_RUN];

  tmr_edge_sync #(.SYNC_DEPTH(SYNC_DEPTH)) u_sync (
    .clk(clk), .rst_n(rst_n), .pin(ext_pin),
    .rise_fast(rise_fast), .rise_safe(rise_safe),
    .level_safe(level_safe), .fall_safe(fall_safe)
  );

  always_comb begin
    src_pulse = 1'b0;
    if (run) begin
      case (mode)
        MODE_INT:       src_pulse = 1'b1;
        MODE_INT_GATED: src_pulse = level_safe;
        MODE_EXT_SYNC:  src_pulse = rise_safe;
        default:        src_pulse = rise_fast;
      endcase
    end
  end

  assign gate_fall_evt = run & (mode == MODE_INT_GATED) & fall_safe;

  tmr_prescaler u_ps (
    .clk(clk), .rst_n(rst_n), .restart(cfg_we | cnt_we),
    .pulse(src_pulse), .sel(ps_sel_e'(ctrl[B_PS_HI:B_PS_LO])), .tick(tick_w)
  );

  tmr_count_core #(.W(W)) u_core (
    .clk(clk), .rst_n(rst_n), .load(cnt_we), .load_val(cnt_wdata),
    .tick(tick_w), .period(per_r), .gate_fall(gate_fall_evt),
    .flag_clr(flag_clr), .count(count_q), .flag(event_flag)
  );

  assign cfg_q    = ctrl;
  assign period_q = per_r;
endmodule

// File: rtl/period_timer_chk.sv
module period_timer_chk #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         run,
  input logic         cnt_we,
  input logic         flag_clr,
  input logic         tick,
  input logic         src_pulse,
  input logic [W-1:0] count,
  input logic [W-1:0] period,
  input logic         flag
);
  a_r6_flag_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !flag_clr) |=> flag);

  a_r2_hold_when_stopped: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_we) |=> $stable(count));

  a_r3_single_step: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_we |=> (count == $past(count) || count == W'($past(count) + 1'b1) || count == '0));

  a_r5_wrap_sets_flag: assert property (@(posedge clk) disable iff (!rst_n)
    (!cnt_we && tick && count == period) |=> (count == '0 && flag));

  a_r4_tick_needs_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> src_pulse);
endmodule

bind period_timer period_timer_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .run(ctrl[15]), .cnt_we(cnt_we),
  .flag_clr(flag_clr), .tick(tick_w), .src_pulse(src_pulse),
  .count(count_q), .period(per_r), .flag(event_flag)
);

// File: tb/test_period_timer.sv
module test_period_timer;
  localparam int W = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, per_we = 0, cnt_we = 0, flag_clr = 0, ext_pin = 0;
  logic [15:0] cfg_wdata = '0;
  logic [W-1:0] per_wdata = '0, cnt_wdata = '0;
  logic [15:0] cfg_q;
  logic [W-1:0] period_q, count_q;
  logic event_flag;

  int checks = 0;
  int errors = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  period_timer #(.W(W)) i_period_timer (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .per_we(per_we), .per_wdata(per_wdata), .cnt_we(cnt_we), .cnt_wdata(cnt_wdata),
    .flag_clr(flag_clr), .ext_pin(ext_pin), .cfg_q(cfg_q), .period_q(period_q),
    .count_q(count_q), .event_flag(event_flag)
  );

  // Cycle model built from the requirements
  logic [15:0] m_cfg;
  logic [W-1:0] m_per, m_cnt;
  logic m_flag;
  logic [2:0] m_sh;
  int unsigned m_pre;

  function automatic int unsigned ratio_of(logic [1:0] f);
    return (f == 2'd0) ? 1 : (f == 2'd1) ? 8 : (f == 2'd2) ? 64 : 256;
  endfunction

  function automatic logic pulse_of(logic [15:0] c, logic [2:0] sh);
    if (!c[15]) return 1'b0;
    if (c[1])   return c[2] ? (sh[1] & ~sh[2]) : (sh[0] & ~sh[1]);
    if (c[7])   return sh[1];
    return 1'b1;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_cfg = '0; m_per = '1; m_cnt = '0; m_flag = 0; m_sh = '0; m_pre = 0;
    end else begin
      logic p, t, hit, gf;
      p  = pulse_of(m_cfg, m_sh);
      gf = m_cfg[15] && !m_cfg[1] && m_cfg[7] && m_sh[2] && !m_sh[1];
      t  = 0;
      if (cfg_we || cnt_we) m_pre = 0;
      else if (p) begin
        if (m_pre == ratio_of(m_cfg[5:4]) - 1) begin m_pre = 0; t = 1; end
        else m_pre = m_pre + 1;
      end
      hit = t && !cnt_we && (m_cnt == m_per);
      if (cnt_we) m_cnt = cnt_wdata;
      else if (t) m_cnt = hit ? '0 : W'(m_cnt + 1);
      if (hit || gf) m_flag = 1;
      else if (flag_clr) m_flag = 0;
      if (cfg_we) m_cfg = cfg_wdata & 16'h80B6;
      if (per_we) m_per = per_wdata;
      m_sh = {m_sh[1:0], ext_pin};
    end
  end

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  task automatic check_all(string tag);
    chk(tag, "count", int'(count_q), int'(m_cnt));
    chk(tag, "flag", int'(event_flag), int'(m_flag));
    chk(tag, "cfg", int'(cfg_q), int'(m_cfg));
    chk(tag, "period", int'(period_q), int'(m_per));
  endtask

  task automatic cyc();
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0; per_we = 0; cnt_we = 0; flag_clr = 0;
  endtask

  task automatic run(int n, string tag);
    for (int i = 0; i < n; i++) begin cyc(); check_all(tag); end
  endtask

  task automatic wr_cfg(logic [15:0] v); cfg_we = 1; cfg_wdata = v; endtask
  task automatic wr_cnt(logic [W-1:0] v); cnt_we = 1; cnt_wdata = v; endtask
  task automatic wr_per(logic [W-1:0] v); per_we = 1; per_wdata = v; endtask

  task automatic summary();
    if (!finished) begin
      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  initial begin
    #(4 * 150000);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=completion");
    summary();
  end

  initial begin
    int c0;
    void'($urandom(32'd5150));
    repeat (3) @(negedge clk);
    rst_n = 1;
    // R1 reset state
    chk("R1", "count", int'(count_q), 0);
    chk("R1", "period", int'(period_q), 16'hFFFF);
    chk("R1", "cfg", int'(cfg_q), 0);
    chk("R1", "flag", int'(event_flag), 0);

    // R2 stopped timer holds
    run(6, "R2");
    chk("R2", "count held", int'(count_q), 0);

    // R3 internal, prescale 1, reserved bits dropped
    wr_cfg(16'hFFFF & ~16'h00B6 | 16'h8000);
    cyc(); chk("R3", "count in write cycle", int'(count_q), 0);
    chk("R3", "cfg mask", int'(cfg_q), 16'h8000);
    cyc(); chk("R3", "first step", int'(count_q), 1);
    run(10, "R3");

    // R12 period write, R5 wrap with flag
    wr_per(16'd3); wr_cnt('0);
    cyc(); chk("R12", "period", int'(period_q), 3);
    run(4, "R5");
    chk("R5", "wrap count", int'(count_q), 0);
    chk("R5", "wrap flag", int'(event_flag), 1);

    // R6 clear
    flag_clr = 1;
    cyc(); chk("R6", "flag cleared", int'(event_flag), 0);
    run(20, "R6");
    wr_per(16'd0); run(8, "R5");
    wr_per(16'hFFFF); cyc();

    // R4 prescale 64 boundary, then each setting
    wr_cfg(16'h8020); wr_cnt('0); cyc();
    for (int i = 0; i < 63; i++) cyc();
    chk("R4", "before 64th", int'(count_q), 0);
    cyc(); chk("R4", "at 64th", int'(count_q), 1);
    for (int s = 0; s < 4; s++) begin
      wr_cfg(16'h8000 | 16'(s << 4)); run(600, "R4");
    end

    // R11 counter write restarts prescale
    wr_cfg(16'h8010); wr_cnt(16'd100); run(5, "R11");
    wr_cnt(16'd200); cyc();
    for (int i = 0; i < 7; i++) cyc();
    chk("R11", "prescale restarted", int'(count_q), 200);
    cyc(); chk("R11", "after 8", int'(count_q), 201);

    // R7 gated internal
    ext_pin = 0; wr_cfg(16'h8080); wr_cnt('0); run(4, "R7");
    ext_pin = 1; cyc(); cyc(); c0 = count_q;
    cyc(); chk("R7", "gate opens", int'(count_q), c0 + 1);
    run(10, "R7");
    ext_pin = 0; run(4, "R7");
    chk("R7", "gate fall flag", int'(event_flag), 1);
    for (int i = 0; i < 200; i++) begin
      if ($urandom % 3 == 0) ext_pin = ~ext_pin;
      if ($urandom % 9 == 0) flag_clr = 1;
      cyc(); check_all("R7");
    end

    // R8 gate ignored with external source
    ext_pin = 0; wr_cfg(16'h8086); run(5, "R8");
    c0 = count_q; ext_pin = 1; run(10, "R8");
    chk("R8", "level gives one count", int'(count_q), c0 + 1);

    // R9 synchronised external latency
    ext_pin = 0; wr_cfg(16'h8006); run(5, "R9");
    c0 = count_q; ext_pin = 1;
    cyc(); chk("R9", "edge1", int'(count_q), c0);
    cyc(); chk("R9", "edge2", int'(count_q), c0);
    cyc(); chk("R9", "edge3", int'(count_q), c0 + 1);

    // R10 single-stage external latency
    ext_pin = 0; wr_cfg(16'h8002); run(5, "R10");
    c0 = count_q; ext_pin = 1;
    cyc(); chk("R10", "edge1", int'(count_q), c0);
    cyc(); chk("R10", "edge2", int'(count_q), c0 + 1);

    // Random mix
    for (int i = 0; i < 4000; i++) begin
      if ($urandom % 40 == 0)
        wr_cfg({($urandom % 5 != 0), 7'd0, 1'($urandom), 1'b0, 1'b0, 1'($urandom % 4 == 0),
                2'b00, 1'($urandom), 1'($urandom), 1'b0});
      if ($urandom % 60 == 0) wr_per(W'($urandom % 48));
      if ($urandom % 80 == 0) wr_cnt(W'($urandom % 40));
      if ($urandom % 10 == 0) flag_clr = 1;
      if ($urandom % 4 == 0)  ext_pin = ~ext_pin;
      cyc(); check_all("R6");
    end

    summary();
  end
endmodule